// File: doc/BRIEF.md
# Mode-Dependent Interrupt Event Register

This block gathers single-cycle event pulses from the receive path, the transmit path and the FIFO logic of a serial infrared link controller. It latches each pulse into one of 13 sticky status bits and drives one interrupt line to the CPU. Three bit positions are shared. Which event drives them depends on the current link mode: the asynchronous byte-oriented mode (SIR), the medium-rate framed mode (MIR) or the fast framed mode (FIR). One bit only counts in the automatic level-copy receive mode.

Software reads the register through a one-cycle read strobe. The read returns the live contents on `status` and, at the same clock edge, clears every bit. An event that lands in the same cycle as that read survives the clear. The transmit-empty event is qualified so that a software clear of the transmit FIFO never reports a finished frame. The qualifier stays blocked until new data is written into the transmit FIFO. The interrupt line is the OR of all status bits gated by an externally held enable vector. Status bits latch whether or not they are enabled.

Top module: `irev_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all 13 status bits become 0 at that edge, whatever events are present.
- R2: A status bit stays at 1 until a read. When `rd_strobe` is high at an edge, `status` shows the contents in that cycle, and after the edge every bit not set by a new event is 0.
- R3: Bit 0 sets from `ev_rx_byte` only while `link_mode` is 0 (SIR). In every other mode it ignores the pulse.
- R4: Bit 1 sets from `ev_eof_char` when `link_mode` is 0 (SIR), and from `ev_stop_flag` when `link_mode` is 1 (MIR) or 2 (FIR). The other input of the pair is ignored in each case.
- R5: Bit 7 sets from `ev_stopbit_miss` in mode 0, from `ev_abort` in mode 1 and from `ev_decode_err` in mode 2. The other two inputs are ignored.
- R6: Bit 3 sets when `tx_frame_done`, `tx_fifo_empty` and `tx_shift_empty` are all high and `tx_fifo_clear` is low. After a `tx_fifo_clear` pulse, bit 3 cannot set until a later `tx_fifo_write` cycle. If a clear and a write occur in the same cycle, the clear wins.
- R7: Bit 6 sets when `ev_last_read` is high and `rx_fifo_empty` is high in the same cycle. `ev_last_read` alone does nothing.
- R8: Bit 12 sets from `ev_read_en` only while `auto_copy` is high.
- R9: Bits 2, 4 and 5 set from `ev_timeout`, `ev_crc_err` and `ev_overrun`. Bits 8 to 11 set from `ev_window[0]` to `ev_window[3]`. These bits behave the same in every mode.
- R10: An event pulse in the same cycle as `rd_strobe` leaves its bit at 1 after the clear.
- R11: `irq` is high exactly when some status bit and the enable bit at the same position are both 1. `enable` has no effect on latching.
- R12: `link_mode` 3 is reserved. In that mode, bits 0, 1 and 7 ignore all of their sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_mode | input | 2 | 0 SIR, 1 MIR, 2 FIR, 3 reserved |
| auto_copy | input | 1 | Automatic level-copy receive mode active |
| rd_strobe | input | 1 | One-cycle CPU read of the register, clears it |
| enable | input | 13 | Per-bit interrupt enable |
| ev_rx_byte | input | 1 | Received byte moved to receive FIFO |
| ev_eof_char | input | 1 | End-of-frame character written to FIFO |
| ev_stop_flag | input | 1 | Stop flag detected |
| ev_timeout | input | 1 | Receive timeout |
| tx_frame_done | input | 1 | Transmit frame finished |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_shift_empty | input | 1 | Transmit shift register empty level |
| tx_fifo_clear | input | 1 | Software clear of transmit FIFO |
| tx_fifo_write | input | 1 | Data written into transmit FIFO |
| ev_crc_err | input | 1 | CRC error |
| ev_overrun | input | 1 | Receive overrun |
| ev_last_read | input | 1 | CPU read the last byte of a frame |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| ev_stopbit_miss | input | 1 | Missing stop bit |
| ev_abort | input | 1 | Abort sequence received |
| ev_decode_err | input | 1 | Symbol decode error |
| ev_window | input | 4 | Multi-window events for bits 8 to 11 |
| ev_read_en | input | 1 | Frame ready to read (level-copy mode) |
| status | output | 13 | Current status bits, the read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds `irev_top` with its package defaults: 13 status bits, a 2-bit mode code and four multi-window event inputs. With these values every bit position is reachable, and so are all four mode codes, including the reserved one. Random cycles mix all event sources with reads, mode changes, transmit FIFO clears and writes, and occasional resets. This covers read-versus-event collisions and the clear-blocks-until-write window on bit 3, which the directed cases also probe one at a time.

// File: rtl/irev_pkg.sv
// Package: shared widths, bit positions and mode encoding for the interrupt
// event register. Assumes a fixed 13-bit register layout that software decodes.
package irev_pkg;
    localparam int EVT_W  = 13;
    localparam int MODE_W = 2;
    localparam int WIN_W  = 4;

    // Bit positions; software decodes these, so they are fixed.
    localparam int B_RXBYTE = 0;
    localparam int B_RXEND  = 1;
    localparam int B_TMO    = 2;
    localparam int B_TXE    = 3;
    localparam int B_CRC    = 4;
    localparam int B_OVR    = 5;
    localparam int B_LAST   = 6;
    localparam int B_RXERR  = 7;
    localparam int B_WIN0   = 8;
    localparam int B_RDEN   = 12;

    typedef enum logic [MODE_W-1:0] {
        LM_SIR = 2'd0,
        LM_MIR = 2'd1,
        LM_FIR = 2'd2,
        LM_RSV = 2'd3
    } link_mode_e;

    typedef logic [EVT_W-1:0] evt_vec_t;
endpackage

// File: rtl/irev_tx_qual.sv
// Module: transmit-empty qualifier. Produces a one-cycle set request for the
// transmit-empty bit when a frame finishes with FIFO and shift register empty.
// A software FIFO clear blocks the request until data is written again.
// Assumes the frame-done input is a single-cycle pulse.
module irev_tx_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic fifo_empty,
    input  logic shift_empty,
    input  logic fifo_clear,
    input  logic fifo_write,
    output logic txe_set
);
    logic blocked;

    // Track whether the last FIFO action was a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          blocked <= 1'b0;
        else if (fifo_clear) blocked <= 1'b1;
        else if (fifo_write) blocked <= 1'b0;
    end

    // Qualify the frame-done pulse with both empty levels and the block.
    always_comb begin
        txe_set = frame_done & fifo_empty & shift_empty & ~fifo_clear & ~blocked;
    end
endmodule

// File: rtl/irev_mode_mux.sv
// Module: event-to-bit mapping. Combines raw event pulses into the 13-bit
// set vector, routing the shared positions by link mode and gating the
// SIR-only and level-copy-only sources. Purely combinational.
module irev_mode_mux
    import irev_pkg::*;
(
    input  logic [MODE_W-1:0] link_mode,
    input  logic              auto_copy,
    input  logic              ev_rx_byte,
    input  logic              ev_eof_char,
    input  logic              ev_stop_flag,
    input  logic              ev_timeout,
    input  logic              txe_set,
    input  logic              ev_crc_err,
    input  logic              ev_overrun,
    input  logic              ev_last_read,
    input  logic              rx_fifo_empty,
    input  logic              ev_stopbit_miss,
    input  logic              ev_abort,
    input  logic              ev_decode_err,
    input  logic [WIN_W-1:0]  ev_window,
    input  logic              ev_read_en,
    output evt_vec_t          set_vec
);
    link_mode_e mode;
    evt_vec_t   base_vec;
    evt_vec_t   win_vec;

    assign mode    = link_mode_e'(link_mode);
    assign win_vec = evt_vec_t'(ev_window) << B_WIN0;

    // Map each source to its bit, routing the mode-shared positions.
    always_comb begin
        base_vec           = '0;
        base_vec[B_TMO]    = ev_timeout;
        base_vec[B_TXE]    = txe_set;
        base_vec[B_CRC]    = ev_crc_err;
        base_vec[B_OVR]    = ev_overrun;
        base_vec[B_LAST]   = ev_last_read & rx_fifo_empty;
        base_vec[B_RDEN]   = ev_read_en & auto_copy;
        case (mode)
            LM_SIR: begin
                base_vec[B_RXBYTE] = ev_rx_byte;
                base_vec[B_RXEND]  = ev_eof_char;
                base_vec[B_RXERR]  = ev_stopbit_miss;
            end
            LM_MIR: begin
                base_vec[B_RXEND]  = ev_stop_flag;
                base_vec[B_RXERR]  = ev_abort;
            end
            LM_FIR: begin
                base_vec[B_RXEND]  = ev_stop_flag;
                base_vec[B_RXERR]  = ev_decode_err;
            end
            default: ;
        endcase
    end

    assign set_vec = base_vec | win_vec;
endmodule

// File: rtl/irev_status_bank.sv
// Module: bank of sticky status bits with clear-on-read and masked OR.
// A set request in the clearing cycle wins over the clear. Assumes the
// read strobe lasts one cycle per CPU read.
module irev_status_bank #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_clear,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] enable,
    output logic [W-1:0] status,
    output logic         irq
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold one event bit: set has priority over the read clear.
        always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~rd_clear) | set_vec[i];
        end
    end

    // Combine enabled bits into the interrupt line.
    always_comb begin
        irq = |(status & enable);
    end
endmodule

// File: rtl/irev_top.sv
// Module: top of the mode-dependent interrupt event register. Wires the
// transmit qualifier, the mode multiplexer and the status bank. Assumes all
// event inputs are synchronous single-cycle pulses and levels are synchronous.
module irev_top
    import irev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] link_mode,
    input  logic              auto_copy,
    input  logic              rd_strobe,
    input  logic [EVT_W-1:0]  enable,
    input  logic              ev_rx_byte,
    input  logic              ev_eof_char,
    input  logic              ev_stop_flag,
    input  logic              ev_timeout,
    input  logic              tx_frame_done,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic              tx_fifo_clear,
    input  logic              tx_fifo_write,
    input  logic              ev_crc_err,
    input  logic              ev_overrun,
    input  logic              ev_last_read,
    input  logic              rx_fifo_empty,
    input  logic              ev_stopbit_miss,
    input  logic              ev_abort,
    input  logic              ev_decode_err,
    input  logic [WIN_W-1:0]  ev_window,
    input  logic              ev_read_en,
    output logic [EVT_W-1:0]  status,
    output logic              irq
);
    logic     txe_set;
    evt_vec_t set_vec;

    irev_tx_qual u_txq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (tx_frame_done),
        .fifo_empty  (tx_fifo_empty),
        .shift_empty (tx_shift_empty),
        .fifo_clear  (tx_fifo_clear),
        .fifo_write  (tx_fifo_write),
        .txe_set     (txe_set)
    );

    irev_mode_mux u_mux (
        .link_mode       (link_mode),
        .auto_copy       (auto_copy),
        .ev_rx_byte      (ev_rx_byte),
        .ev_eof_char     (ev_eof_char),
        .ev_stop_flag    (ev_stop_flag),
        .ev_timeout      (ev_timeout),
        .txe_set         (txe_set),
        .ev_crc_err      (ev_crc_err),
        .ev_overrun      (ev_overrun),
        .ev_last_read    (ev_last_read),
        .rx_fifo_empty   (rx_fifo_empty),
        .ev_stopbit_miss (ev_stopbit_miss),
        .ev_abort        (ev_abort),
        .ev_decode_err   (ev_decode_err),
        .ev_window       (ev_window),
        .ev_read_en      (ev_read_en),
        .set_vec         (set_vec)
    );

    irev_status_bank #(.W(EVT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_clear (rd_strobe),
        .set_vec  (set_vec),
        .enable   (enable),
        .status   (status),
        .irq      (irq)
    );
endmodule

// File: rtl/irev_chk.sv
// Module: assertion checker for irev_top, attached by bind. Observes the
// set vector between the multiplexer and the bank, and the top-level ports.
module irev_chk
    import irev_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              auto_copy,
    input logic [MODE_W-1:0] link_mode,
    input logic              tx_fifo_clear,
    input logic [EVT_W-1:0]  set_vec,
    input logic [EVT_W-1:0]  status,
    input logic [EVT_W-1:0]  enable,
    input logic              irq
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> status == '0); // R1
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ((status & $past(status)) == $past(status))); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> status == $past(set_vec)); // R2
    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R10
    AST_BYTE_SIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode != 2'd0) |-> !set_vec[B_RXBYTE]); // R3
    AST_TXE_NOT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clear |-> !set_vec[B_TXE]); // R6
    AST_RDEN_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_copy |-> !set_vec[B_RDEN]); // R8
    AST_RSV_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == 2'd3) |-> (!set_vec[B_RXBYTE] && !set_vec[B_RXEND] && !set_vec[B_RXERR])); // R12
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable) == '0) |-> !irq); // R11
endmodule

bind irev_top irev_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_strobe     (rd_strobe),
    .auto_copy     (auto_copy),
    .link_mode     (link_mode),
    .tx_fifo_clear (tx_fifo_clear),
    .set_vec       (set_vec),
    .status        (status),
    .enable        (enable),
    .irq           (irq)
);

// File: tb/sim_irev_top.sv
// Bench: directed corner cases followed by seeded random cycles, compared
// every cycle against a bench reference model written from the requirements.
module sim_irev_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  link_mode = 2'd0;
    logic        auto_copy = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [12:0] enable = '0;
    logic        ev_rx_byte = 0, ev_eof_char = 0, ev_stop_flag = 0, ev_timeout = 0;
    logic        tx_frame_done = 0, tx_fifo_empty = 0, tx_shift_empty = 0;
    logic        tx_fifo_clear = 0, tx_fifo_write = 0;
    logic        ev_crc_err = 0, ev_overrun = 0, ev_last_read = 0, rx_fifo_empty = 0;
    logic        ev_stopbit_miss = 0, ev_abort = 0, ev_decode_err = 0;
    logic [3:0]  ev_window = '0;
    logic        ev_read_en = 0;
    logic [12:0] status;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [12:0] exp_q = '0;
    logic        exp_blk = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irev_top u0 (
        .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .auto_copy(auto_copy),
        .rd_strobe(rd_strobe), .enable(enable), .ev_rx_byte(ev_rx_byte),
        .ev_eof_char(ev_eof_char), .ev_stop_flag(ev_stop_flag), .ev_timeout(ev_timeout),
        .tx_frame_done(tx_frame_done), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .tx_fifo_clear(tx_fifo_clear),
        .tx_fifo_write(tx_fifo_write), .ev_crc_err(ev_crc_err), .ev_overrun(ev_overrun),
        .ev_last_read(ev_last_read), .rx_fifo_empty(rx_fifo_empty),
        .ev_stopbit_miss(ev_stopbit_miss), .ev_abort(ev_abort),
        .ev_decode_err(ev_decode_err), .ev_window(ev_window), .ev_read_en(ev_read_en),
        .status(status), .irq(irq)
    );

    // Expected set requests for the current inputs (R3..R9, R12).
    function automatic logic [12:0] want_set();
        logic [12:0] s = '0;
        s[0]  = ev_rx_byte && link_mode == 2'd0;
        s[1]  = (link_mode == 2'd0 && ev_eof_char) ||
                ((link_mode == 2'd1 || link_mode == 2'd2) && ev_stop_flag);
        s[2]  = ev_timeout;
        s[3]  = tx_frame_done && tx_fifo_empty && tx_shift_empty && !tx_fifo_clear && !exp_blk;
        s[4]  = ev_crc_err;
        s[5]  = ev_overrun;
        s[6]  = ev_last_read && rx_fifo_empty;
        s[7]  = (link_mode == 2'd0 && ev_stopbit_miss) || (link_mode == 2'd1 && ev_abort) ||
                (link_mode == 2'd2 && ev_decode_err);
        s[11:8] = ev_window;
        s[12] = ev_read_en && auto_copy;
        return s;
    endfunction

    function automatic logic want_irq();
        return (exp_q & enable) != '0;
    endfunction

    task automatic clear_pulses();
        rd_strobe = 0; ev_rx_byte = 0; ev_eof_char = 0; ev_stop_flag = 0; ev_timeout = 0;
        tx_frame_done = 0; tx_fifo_clear = 0; tx_fifo_write = 0; ev_crc_err = 0;
        ev_overrun = 0; ev_last_read = 0; ev_stopbit_miss = 0; ev_abort = 0;
        ev_decode_err = 0; ev_window = '0; ev_read_en = 0;
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            exp_q = '0;
            exp_blk = 1'b0;
        end else begin
            exp_q = (rd_strobe ? 13'h0 : exp_q) | want_set();
            if (tx_fifo_clear)      exp_blk = 1'b1;
            else if (tx_fifo_write) exp_blk = 1'b0;
        end
        @(negedge clk);
        n_chk++;
        if (status !== exp_q || irq !== want_irq()) begin
            n_bad++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     tag, status, irq, exp_q, want_irq());
        end
        clear_pulses();
    endtask

    task automatic rd(input string tag);
        rd_strobe = 1;
        cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        enable = 13'h1FFF;
        // R1: events during reset are dropped.
        ev_timeout = 1; ev_crc_err = 1;
        cyc("R1 reset drops events");
        cyc("R1 reset state");
        rst_n = 1;
        cyc("R1 out of reset idle");

        // R3: byte event only in SIR.
        link_mode = 0; ev_rx_byte = 1; cyc("R3 byte in SIR");
        cyc("R2 bit holds");
        rd("R2 read clears");
        for (int m = 1; m < 4; m++) begin
            link_mode = 2'(m); ev_rx_byte = 1; cyc("R3 byte ignored outside SIR");
        end

        // R4/R5/R12: shared positions per mode.
        for (int m = 0; m < 4; m++) begin
            link_mode = 2'(m);
            ev_eof_char = 1;     cyc("R4 end char source");     rd("R4 clear");
            ev_stop_flag = 1;    cyc("R4 stop flag source");    rd("R4 clear");
            ev_stopbit_miss = 1; cyc("R5 stop bit source");     rd("R5 clear");
            ev_abort = 1;        cyc("R5 abort source");        rd("R5 clear");
            ev_decode_err = 1;   cyc("R5 decode source");       rd("R5 clear");
            ev_rx_byte = 1; ev_eof_char = 1; ev_stop_flag = 1;
            ev_stopbit_miss = 1; ev_abort = 1; ev_decode_err = 1;
            cyc("R12 all shared sources"); rd("R12 clear");
        end

        // R6: transmit-empty qualification.
        link_mode = 0; tx_fifo_empty = 1; tx_shift_empty = 1;
        tx_frame_done = 1; cyc("R6 frame done sets"); rd("R6 clear");
        tx_frame_done = 1; tx_fifo_clear = 1; cyc("R6 clear same cycle");
        tx_frame_done = 1; cyc("R6 blocked after clear");
        tx_fifo_clear = 1; tx_fifo_write = 1; cyc("R6 clear beats write");
        tx_frame_done = 1; cyc("R6 still blocked");
        tx_fifo_write = 1; cyc("R6 write rearms");
        tx_frame_done = 1; cyc("R6 rearmed sets"); rd("R6 clear");
        tx_shift_empty = 0; tx_frame_done = 1; cyc("R6 shift busy");
        tx_shift_empty = 1; tx_fifo_empty = 0; tx_frame_done = 1; cyc("R6 fifo busy");

        // R7: last-byte read empties FIFO.
        rx_fifo_empty = 0; ev_last_read = 1; cyc("R7 FIFO not empty");
        rx_fifo_empty = 1; ev_last_read = 1; cyc("R7 last byte empties"); rd("R7 clear");

        // R8: level-copy gating.
        auto_copy = 0; ev_read_en = 1; cyc("R8 ignored");
        auto_copy = 1; ev_read_en = 1; cyc("R8 sets"); rd("R8 clear");

        // R9: mode-independent sources.
        for (int m = 0; m < 4; m++) begin
            link_mode = 2'(m);
            ev_timeout = 1; ev_crc_err = 1; ev_overrun = 1; ev_window = 4'hF;
            cyc("R9 plain sources"); rd("R9 clear");
        end

        // R10: event in the read cycle survives.
        ev_overrun = 1; cyc("R10 prepare");
        ev_crc_err = 1; rd("R10 read with event");
        rd("R10 second read");

        // R11: masking.
        ev_timeout = 1; enable = 13'h0; cyc("R11 masked");
        enable = 13'h0004; cyc("R11 matching enable");
        enable = 13'h1FFB; cyc("R11 other enables");
        rd("R11 clear");

        // Random phase.
        for (int k = 0; k < 4000; k++) begin
            link_mode = 2'($urandom_range(0, 3));
            auto_copy = 1'($urandom_range(0, 1));
            enable = 13'($urandom);
            rd_strobe = ($urandom_range(0, 3) == 0);
            ev_rx_byte = ($urandom_range(0, 7) == 0);
            ev_eof_char = ($urandom_range(0, 7) == 0);
            ev_stop_flag = ($urandom_range(0, 7) == 0);
            ev_timeout = ($urandom_range(0, 15) == 0);
            tx_frame_done = ($urandom_range(0, 3) == 0);
            tx_fifo_empty = ($urandom_range(0, 3) != 0);
            tx_shift_empty = ($urandom_range(0, 3) != 0);
            tx_fifo_clear = ($urandom_range(0, 7) == 0);
            tx_fifo_write = ($urandom_range(0, 5) == 0);
            ev_crc_err = ($urandom_range(0, 15) == 0);
            ev_overrun = ($urandom_range(0, 15) == 0);
            ev_last_read = ($urandom_range(0, 5) == 0);
            rx_fifo_empty = 1'($urandom_range(0, 1));
            ev_stopbit_miss = ($urandom_range(0, 7) == 0);
            ev_abort = ($urandom_range(0, 7) == 0);
            ev_decode_err = ($urandom_range(0, 7) == 0);
            ev_window = 4'($urandom) & 4'($urandom);
            ev_read_en = ($urandom_range(0, 7) == 0);
            rst_n = ($urandom_range(0, 299) != 0);
            cyc("R2 R11 random");
        end
        rst_n = 1;
        cyc("R1 R2 final");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule